// File: doc/BRIEF.md
# Twin Prescaled Reload Timer

This block holds two independent down-counting timers behind one small register interface. Channel 0 is a real-time-clock timer with an 8-bit prescaler. Channel 1 is a general-purpose timer with a 16-bit prescaler. Each channel has a 32-bit counter and a 32-bit reload register. Both prescalers and both counters run from the block clock. A counter steps down once per prescaler period. When a step finds the counter already at zero, the channel emits a one-cycle interrupt pulse. It then either refills the counter from its reload register or stops, depending on the channel's continuous-reload bit.

Software writes the reload and prescaler registers, and a single shared control word that acts on both channels at once. Reads return the live counter and the live prescaler remaining count, not the programmed values. A control write that sets any undefined bit is refused as a parity error, and a one-cycle error pulse is raised.

Top module: `twin_reload_timer`

## Requirements
- R1: After reset, both counters read 0xFFFFFFFF, both reload registers hold 0xFFFFFFFF, both prescalers read 0, both timers are stopped, and no interrupt or error pulse is raised.
- R2: A write to channel 0's prescaler keeps only bits 7:0 of the data. A write to channel 1's prescaler keeps only bits 15:0.
- R3: Register map: address 0 is the channel 0 reload (write) and counter (read). Address 1 is the channel 0 prescaler. Addresses 2 and 3 are the same pair for channel 1. Address 4 is the control word, which is write-only and reads as 0. A running counter with prescaler value P decrements once every P+1 clock cycles.
- R4: With continuous reload set, a step that finds the counter at zero raises a one-cycle interrupt pulse and refills the counter from the reload register. The interrupt period is (N+1)(P+1) cycles.
- R5: With continuous reload clear, the zero step raises one interrupt pulse and stops the timer. The counter then holds 0.
- R6: The control word carries one 4-bit field per channel, at bits 11:8 for channel 0 and bits 3:0 for channel 1. In each field, bit 0 is continuous reload, bit 1 copies the reload register into the counter, bit 2 is enable, and bit 3 restarts the prescaler and applies the enable bit. Every accepted control write updates both continuous-reload bits.
- R7: A control write with the restart bit and the enable bit set starts a stopped timer. A write with the restart bit set and the enable bit clear stops it, and its counter then holds still.
- R8: The prescaler read of a running timer returns the prescaler value minus the cycles already elapsed in the current period.
- R9: A control write with any bit set outside 0x00000F0F changes no state and raises the error output for exactly one cycle. An accepted control write raises no error.
- R10: A reload-register write leaves the counter unchanged. The next refill, whether by zero step or by control, uses the new value.
- R11: The two channels count and interrupt independently of each other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Write register address |
| wr_data | input | DATA_W | Write data |
| rd_addr | input | ADDR_W | Read register address |
| rd_data | output | DATA_W | Combinational read data |
| irq_o | output | 2 | One-cycle interrupt pulse per channel (bit 0 = channel 0) |
| ctrl_err_o | output | 1 | One-cycle pulse after a refused control write |

## Verification
The bench builds the block with its defaults: 32-bit counters, an 8-bit prescaler on channel 0 and a 16-bit prescaler on channel 1. It programs small counts and prescaler values, so underflow, refill, one-shot stop and the (N+1)(P+1) period all fall within a few dozen cycles. Overlapping periods on both channels are also placed inside that window. Writing values wider than each prescaler puts the byte and halfword masking within reach. The full 32-bit run-down from the reset value is not exercised by counting.

// File: rtl/twt_pkg.sv
package twt_pkg;

  localparam int NCH         = 2;
  localparam int CTL_FIELD_W = 4;
  localparam int CTL_REG     = 4;
  localparam logic [31:0] CTL_LEGAL = 32'h0000_0F0F;

  // one control field per channel, bit 0 at the bottom
  typedef struct packed {
    logic ld_pre;   // restart prescaler, apply enable
    logic en;       // enable value
    logic ld_cnt;   // copy reload into counter
    logic cont;     // continuous reload
  } twt_ctl_t;

  function automatic int ctl_lsb(input int ch);
    return (ch == 0) ? 8 : 0;
  endfunction

  function automatic int rld_reg(input int ch);
    return 2 * ch;
  endfunction

  function automatic int pre_reg(input int ch);
    return 2 * ch + 1;
  endfunction

endpackage

// File: rtl/twt_rst_sync.sv
module twt_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_n_sync = sync_q[STAGES-1];
endmodule

// File: rtl/twt_ctrl_decode.sv
module twt_ctrl_decode
  import twt_pkg::*;
#(
  parameter int ADDR_W = 3,
  parameter int DATA_W = 32
) (
  input  logic                  wr_en,
  input  logic [ADDR_W-1:0]     wr_addr,
  input  logic [DATA_W-1:0]     wr_data,
  output logic                  accept,
  output logic                  reject,
  output twt_ctl_t [NCH-1:0]    ctl
);
  localparam logic [DATA_W-1:0] LEGAL = DATA_W'(CTL_LEGAL);

  logic hit;
  logic bad;

  always_comb begin
    hit    = wr_en && (wr_addr == ADDR_W'(CTL_REG));
    bad    = |(wr_data & ~LEGAL);
    accept = hit && !bad;
    reject = hit && bad;
  end

  for (genvar ch = 0; ch < NCH; ch++) begin : g_field
    localparam int LSB = ctl_lsb(ch);
    assign ctl[ch] = twt_ctl_t'(wr_data[LSB +: CTL_FIELD_W]);
  end
endmodule

// File: rtl/twt_prescaler.sv
module twt_prescaler #(
  parameter int PRE_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_val,
  input  logic [PRE_W-1:0] val_in,
  input  logic             restart,
  input  logic             active,
  output logic             tick,
  output logic [PRE_W-1:0] rem_o
);
  logic [PRE_W-1:0] val_q, val_d;
  logic [PRE_W-1:0] rem_q, rem_d;
  logic             val_en, rem_en;

  always_comb begin
    val_en = wr_val;
    val_d  = val_in;
    rem_en = restart || active;
    rem_d  = rem_q;
    tick   = 1'b0;
    if (restart) begin
      rem_d = val_q;
    end else if (active) begin
      if (rem_q == '0) begin
        rem_d = val_q;
        tick  = 1'b1;
      end else begin
        rem_d = rem_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      val_q <= '0;
      rem_q <= '0;
    end else begin
      if (val_en) val_q <= val_d;
      if (rem_en) rem_q <= rem_d;
    end
  end

  assign rem_o = rem_q;
endmodule

// File: rtl/twt_channel.sv
module twt_channel
  import twt_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int PRE_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_rld,
  input  logic              wr_pre,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              ctl_valid,
  input  twt_ctl_t          ctl,
  output logic [DATA_W-1:0] cnt_o,
  output logic [DATA_W-1:0] pre_o,
  output logic              run_o,
  output logic              cont_o,
  output logic              irq_o
);
  logic [DATA_W-1:0] cnt_q, cnt_d, rld_q, rld_d;
  logic              run_q, run_d, cont_q, cont_d, irq_q, irq_d;
  logic              cnt_en, rld_en, run_en, cont_en;
  logic              tick;
  logic [PRE_W-1:0]  rem;
  logic              restart;

  assign restart = ctl_valid && ctl.ld_pre;

  twt_prescaler #(.PRE_W(PRE_W)) u_pre (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_val  (wr_pre),
    .val_in  (wr_data[PRE_W-1:0]),
    .restart (restart),
    .active  (run_q),
    .tick    (tick),
    .rem_o   (rem)
  );

  always_comb begin
    cnt_d  = cnt_q;
    run_d  = run_q;
    cont_d = cont_q;
    irq_d  = 1'b0;
    rld_d  = wr_data;
    rld_en = wr_rld;
    if (tick) begin
      if (cnt_q == '0) begin
        irq_d = 1'b1;
        if (cont_q) cnt_d = rld_q;
        else        run_d = 1'b0;
      end else begin
        cnt_d = cnt_q - 1'b1;
      end
    end
    if (ctl_valid) begin
      cont_d = ctl.cont;
      if (ctl.ld_cnt) cnt_d = rld_q;
      if (ctl.ld_pre) run_d = ctl.en;
    end
    cnt_en  = tick || (ctl_valid && ctl.ld_cnt);
    run_en  = tick || restart;
    cont_en = ctl_valid;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '1;
      rld_q  <= '1;
      run_q  <= 1'b0;
      cont_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      if (cnt_en)  cnt_q  <= cnt_d;
      if (rld_en)  rld_q  <= rld_d;
      if (run_en)  run_q  <= run_d;
      if (cont_en) cont_q <= cont_d;
      irq_q <= irq_d;
    end
  end

  assign cnt_o  = cnt_q;
  assign pre_o  = {{(DATA_W-PRE_W){1'b0}}, rem};
  assign run_o  = run_q;
  assign cont_o = cont_q;
  assign irq_o  = irq_q;
endmodule

// File: rtl/twin_reload_timer.sv
module twin_reload_timer
  import twt_pkg::*;
#(
  parameter int ADDR_W    = 3,
  parameter int DATA_W    = 32,
  parameter int RTC_PRE_W = 8,
  parameter int GPT_PRE_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic [NCH-1:0]    irq_o,
  output logic              ctrl_err_o
);
  logic                           rst_n_sync;
  logic                           ctl_accept, ctl_reject;
  twt_ctl_t [NCH-1:0]             ctl;
  logic [NCH-1:0][DATA_W-1:0]     ch_cnt, ch_pre;
  logic [NCH-1:0]                 ch_run, ch_cont, ch_irq;
  logic                           err_q, err_d;

  twt_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_sync)
  );

  twt_ctrl_decode #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dec (
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .accept  (ctl_accept),
    .reject  (ctl_reject),
    .ctl     (ctl)
  );

  for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
    localparam int PW = (ch == 0) ? RTC_PRE_W : GPT_PRE_W;
    logic wr_rld, wr_pre;
    assign wr_rld = wr_en && (wr_addr == ADDR_W'(rld_reg(ch)));
    assign wr_pre = wr_en && (wr_addr == ADDR_W'(pre_reg(ch)));

    twt_channel #(.DATA_W(DATA_W), .PRE_W(PW)) u_chan (
      .clk       (clk),
      .rst_n     (rst_n_sync),
      .wr_rld    (wr_rld),
      .wr_pre    (wr_pre),
      .wr_data   (wr_data),
      .ctl_valid (ctl_accept),
      .ctl       (ctl[ch]),
      .cnt_o     (ch_cnt[ch]),
      .pre_o     (ch_pre[ch]),
      .run_o     (ch_run[ch]),
      .cont_o    (ch_cont[ch]),
      .irq_o     (ch_irq[ch])
    );
  end

  always_comb begin
    rd_data = '0;
    for (int c = 0; c < NCH; c++) begin
      if (rd_addr == ADDR_W'(rld_reg(c))) rd_data = ch_cnt[c];
      if (rd_addr == ADDR_W'(pre_reg(c))) rd_data = ch_pre[c];
    end
  end

  assign err_d = ctl_reject;

  always_ff @(posedge clk or negedge rst_n_sync) begin
    if (!rst_n_sync) err_q <= 1'b0;
    else             err_q <= err_d;
  end

  assign irq_o      = ch_irq;
  assign ctrl_err_o = err_q;
endmodule

// File: rtl/twt_checker.sv
module twt_checker
  import twt_pkg::*;
#(
  parameter int ADDR_W = 3,
  parameter int DATA_W = 32
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       wr_en,
  input logic [ADDR_W-1:0]          wr_addr,
  input logic [DATA_W-1:0]          wr_data,
  input logic [NCH-1:0]             irq,
  input logic                       ctrl_err,
  input logic [NCH-1:0][DATA_W-1:0] cnt,
  input logic [NCH-1:0][DATA_W-1:0] pre,
  input logic [NCH-1:0]             run,
  input logic [NCH-1:0]             cont
);
  logic ctl_wr;
  logic ctl_bad;
  assign ctl_wr  = wr_en && (wr_addr == ADDR_W'(CTL_REG));
  assign ctl_bad = |(wr_data & ~DATA_W'(CTL_LEGAL));

  AST_BAD_CTRL_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wr && ctl_bad) |=> ctrl_err); // R9
  AST_ERR_ONLY_BAD: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_err |-> $past(ctl_wr && ctl_bad)); // R9

  for (genvar ch = 0; ch < NCH; ch++) begin : g_chk
    AST_IRQ_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      irq[ch] |-> ($past(cnt[ch]) == '0)); // R4
    AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (run[ch] && pre[ch] == '0 && cnt[ch] != '0 && !ctl_wr)
      |=> cnt[ch] == $past(cnt[ch]) - 1'b1); // R3
    AST_PRE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (run[ch] && pre[ch] != '0 && !ctl_wr)
      |=> pre[ch] == $past(pre[ch]) - 1'b1); // R8
    AST_STOPPED_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (!run[ch] && !ctl_wr) |=> $stable(cnt[ch])); // R7
    AST_ONESHOT_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
      (irq[ch] && !$past(cont[ch]) && !$past(ctl_wr)) |-> !run[ch]); // R5
  end
endmodule

bind twin_reload_timer twt_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_twt_chk (
  .clk      (clk),
  .rst_n    (rst_n_sync),
  .wr_en    (wr_en),
  .wr_addr  (wr_addr),
  .wr_data  (wr_data),
  .irq      (irq_o),
  .ctrl_err (ctrl_err_o),
  .cnt      (ch_cnt),
  .pre      (ch_pre),
  .run      (ch_run),
  .cont     (ch_cont)
);

// File: tb/twin_reload_timer_bench.sv
module twin_reload_timer_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [2:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic [1:0]  irq_o;
  logic        ctrl_err_o;

  int nchk = 0;
  int nfail = 0;
  int cyc = 0;
  bit mon_on = 1'b0;
  bit done = 1'b0;
  int exp0[$];
  int exp1[$];

  twin_reload_timer u_twin_reload_timer (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .wr_addr    (wr_addr),
    .wr_data    (wr_data),
    .rd_addr    (rd_addr),
    .rd_data    (rd_data),
    .irq_o      (irq_o),
    .ctrl_err_o (ctrl_err_o)
  );

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic rd_chk(input logic [2:0] a, input logic [31:0] exp, input string req);
    rd_addr = a;
    #1;
    chk(req, rd_data, exp);
  endtask

  task automatic rd_val(input logic [2:0] a, output logic [31:0] v);
    rd_addr = a;
    #1;
    v = rd_data;
  endtask

  // write lands on the next rising edge; k is the cycle count after it
  task automatic wr(input logic [2:0] a, input logic [31:0] d, output int k);
    @(negedge clk);
    wr_addr = a;
    wr_data = d;
    wr_en   = 1'b1;
    k = cyc + 1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wait_to(input int t);
    while (cyc < t) @(negedge clk);
  endtask

  // driver side of the scoreboard
  task automatic expect_irq(input int ch, input int at);
    if (ch == 0) exp0.push_back(at);
    else         exp1.push_back(at);
  endtask

  // monitor side of the scoreboard
  always @(negedge clk) begin
    if (mon_on) begin
      if (irq_o[0]) begin
        if (exp0.size() == 0) chk("R4 ch0 unexpected irq", cyc, 0);
        else chk("R4 ch0 irq cycle", cyc, exp0.pop_front());
      end
      if (irq_o[1]) begin
        if (exp1.size() == 0) chk("R11 ch1 unexpected irq", cyc, 0);
        else chk("R11 ch1 irq cycle", cyc, exp1.pop_front());
      end
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog: got hang expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end

  initial begin
    int k, k2;
    logic [31:0] v0, v2, va;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    mon_on = 1'b1;

    // R1 reset state
    rd_chk(3'd0, 32'hFFFF_FFFF, "R1 cnt0");
    rd_chk(3'd2, 32'hFFFF_FFFF, "R1 cnt1");
    rd_chk(3'd1, 32'h0, "R1 pre0");
    rd_chk(3'd3, 32'h0, "R1 pre1");
    chk("R1 irq", {30'd0, irq_o}, 32'h0);
    chk("R1 err", {31'd0, ctrl_err_o}, 32'h0);
    wr(3'd4, 32'h0000_0202, k);
    rd_chk(3'd0, 32'hFFFF_FFFF, "R1 reload0");
    rd_chk(3'd2, 32'hFFFF_FFFF, "R1 reload1");
    rd_chk(3'd4, 32'h0, "R3 ctrl reads zero");

    // R2 prescaler widths
    wr(3'd1, 32'h0000_1234, k);
    wr(3'd3, 32'h0001_2345, k);
    wr(3'd4, 32'h0000_0808, k);
    rd_chk(3'd1, 32'h34, "R2 pre0 byte");
    rd_chk(3'd3, 32'h2345, "R2 pre1 halfword");
    repeat (5) @(negedge clk);
    rd_chk(3'd1, 32'h34, "R7 stopped pre0");

    // R3 R4 R8 continuous channel 0, N=4 P=3
    wr(3'd1, 32'd3, k);
    wr(3'd0, 32'd4, k);
    wr(3'd4, 32'h0000_0F00, k);
    expect_irq(0, k + 20);
    expect_irq(0, k + 40);
    expect_irq(0, k + 60);
    wait_to(k + 2);
    rd_chk(3'd1, 32'd1, "R8 live pre");
    rd_chk(3'd0, 32'd4, "R3 cnt before step");
    wait_to(k + 4);
    rd_chk(3'd0, 32'd3, "R3 cnt after one period");
    wait_to(k + 5);
    rd_chk(3'd1, 32'd2, "R8 live pre second period");
    wait_to(k + 20);
    rd_chk(3'd0, 32'd4, "R4 refilled");
    wait_to(k + 62);
    wr(3'd4, 32'h0000_0800, k2);
    chk("R9 good write no err", {31'd0, ctrl_err_o}, 32'h0);
    rd_val(3'd0, va);
    repeat (25) @(negedge clk);
    rd_chk(3'd0, va, "R7 stopped counter holds");

    // R5 one-shot channel 1, N=2 P=1
    wr(3'd3, 32'd1, k);
    wr(3'd2, 32'd2, k);
    wr(3'd4, 32'h0000_000E, k);
    expect_irq(1, k + 6);
    wait_to(k + 20);
    rd_chk(3'd2, 32'd0, "R5 one-shot holds zero");
    wait_to(k + 40);
    rd_chk(3'd2, 32'd0, "R5 still stopped");

    // R11 both channels together
    wr(3'd1, 32'd1, k);
    wr(3'd0, 32'd2, k);
    wr(3'd3, 32'd4, k);
    wr(3'd2, 32'd1, k);
    wr(3'd4, 32'h0000_0F0F, k);
    expect_irq(0, k + 6);
    expect_irq(0, k + 12);
    expect_irq(0, k + 18);
    expect_irq(0, k + 24);
    expect_irq(1, k + 10);
    expect_irq(1, k + 20);
    wait_to(k + 25);
    wr(3'd4, 32'h0000_0808, k2);

    // R9 refused control write
    rd_val(3'd0, v0);
    rd_val(3'd2, v2);
    wr(3'd4, 32'h0000_1F0F, k);
    chk("R9 err pulse", {31'd0, ctrl_err_o}, 32'h1);
    @(negedge clk);
    chk("R9 err one cycle", {31'd0, ctrl_err_o}, 32'h0);
    repeat (10) @(negedge clk);
    rd_chk(3'd0, v0, "R9 cnt0 untouched");
    rd_chk(3'd2, v2, "R9 cnt1 untouched");

    // R10 reload write, R6 load counter
    wr(3'd0, 32'd7, k);
    rd_chk(3'd0, v0, "R10 reload write keeps counter");
    wr(3'd4, 32'h0000_0200, k);
    rd_chk(3'd0, 32'd7, "R6 load counter");
    wr(3'd1, 32'd0, k);
    wr(3'd0, 32'd2, k);
    wr(3'd4, 32'h0000_0F00, k);
    expect_irq(0, k + 3);
    expect_irq(0, k + 9);
    wr(3'd0, 32'd5, k2);
    wait_to(k + 3);
    rd_chk(3'd0, 32'd5, "R10 refill uses new reload");
    wait_to(k + 10);
    wr(3'd4, 32'h0000_0800, k2);

    repeat (20) @(negedge clk);
    chk("R4 all ch0 irqs seen", exp0.size(), 0);
    chk("R5 all ch1 irqs seen", exp1.size(), 0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule